// File: doc/BRIEF.md
# Reservation Monitor for Linked-Load / Conditional-Store Atomics

This block sits beside one processor port and lets that port build atomic read-modify-write sequences from two operations. The first is a linked load, which reads a word and arms a reservation on the cache block that holds it. The second is a conditional store, which writes back only if the reservation is still intact. While the reservation is armed, the monitor watches a snoop stream of block numbers written by other agents. A matching snooped write disarms the reservation. A store from the port itself to the same block also disarms it.

A conditional store whose reservation is already broken when it arrives is rejected at once. It raises no bus request and performs no memory write. If the reservation is intact, the monitor raises a bus request and holds it until it is granted. A matching snooped write that appears before or together with the grant means another agent's store won the block first, so the pending store is dropped without writing. Every operation ends with a one-cycle done pulse and a success flag. A linked load also returns its read data.

Top module: `llsc_monitor`

## Requirements
- R1: Operation encoding on `req_op`: 1 is a linked load, 2 is a conditional store and 3 is an ordinary store. A linked load accepted at a clock edge issues a memory read in that cycle. The read data comes back one cycle later. Two cycles after acceptance, `rsp_done` pulses with `rsp_ok`=1 and `rsp_rdata` equal to the word read.
- R2: A linked load arms a reservation on its block, where the block is the address with the low OFF_W bits (4 by default) dropped. A conditional store to any address in that block, with no intervening write, raises `bus_req`. On grant it writes memory exactly once and reports `rsp_ok`=1.
- R3: If a snooped write to the reserved block arrives before the conditional store, the store fails. It raises no `bus_req` and performs no memory write.
- R4: Snooped writes to other blocks leave the reservation armed.
- R5: While a conditional store waits for the bus, `bus_req` stays high until grant. If a matching snooped write arrives before or in the same cycle as `bus_gnt`, the store fails, `bus_req` drops and memory is not written.
- R6: A conditional store with no armed reservation, or to a different block, fails and disarms any reservation.
- R7: A successful conditional store disarms the reservation, so a second conditional store to the same block fails.
- R8: A new linked load replaces any earlier reservation.
- R9: An ordinary store writes memory at once and reports `rsp_ok`=1. It disarms the reservation if it targets the reserved block and leaves it armed otherwise.
- R10: `rsp_done` rises in the cycle after the edge at which an operation commits or is rejected. For ordinary stores and conditional stores rejected on arrival, that is one cycle after acceptance. For a conditional store granted in its first bus cycle, it is two cycles after acceptance.
- R11: After reset, `rsp_done`, `bus_req` and `mem_we` are low, `req_ready` is high and no reservation is armed.
- R12: A snooped write to the same block in the cycle a linked load is accepted leaves the reservation disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_op | input | 2 | Operation: 1 linked load, 2 conditional store, 3 store |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Monitor idle and accepting a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Success flag, valid with `rsp_done` |
| rsp_rdata | output | DATA_W | Linked-load read data, valid with `rsp_done` |
| snp_valid | input | 1 | Another agent wrote memory this cycle |
| snp_blk | input | ADDR_W-OFF_W | Block number of that write |
| bus_req | output | 1 | Bus request for a conditional store |
| bus_gnt | input | 1 | Bus grant |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_re` |

## Verification
The bench aims at the block-granularity compare. It sends conditional stores to a different offset in the reserved block and snoops to a neighbouring block. A monitor that compared full addresses would reject the first, and one that masked too many bits would kill on the second. The bench also sends a snoop in the same cycle as a grant and another in the same cycle as a linked load. If the grant took priority, memory would be written. If the load won, a stale reservation would later let a store through. The bench counts memory writes and bus-request cycles, so a store rejected on arrival that still arbitrates, or writes anyway, is caught. Every success is followed by reading the word back.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LL   = 2'd1,
    OP_SC   = 2'd2,
    OP_ST   = 2'd3
  } llsc_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_ARB  = 2'd2
  } llsc_state_e;
endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [BLK_W-1:0] set_blk_i,
  input  logic             clr_i,
  input  logic             snp_valid_i,
  input  logic [BLK_W-1:0] snp_blk_i,
  input  logic [BLK_W-1:0] probe_blk_i,
  output logic             probe_hit_o,
  output logic             snp_kill_o
);
  logic             valid_q;
  logic [BLK_W-1:0] blk_q;
  logic             snp_on_set;

  function automatic logic blk_eq(input logic [BLK_W-1:0] a, input logic [BLK_W-1:0] b);
    return a == b;
  endfunction

  assign snp_kill_o  = valid_q && snp_valid_i && blk_eq(snp_blk_i, blk_q);
  assign probe_hit_o = valid_q && blk_eq(probe_blk_i, blk_q);
  assign snp_on_set  = snp_valid_i && blk_eq(snp_blk_i, set_blk_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
    end else if (set_i) begin
      valid_q <= !snp_on_set;
      blk_q   <= set_blk_i;
    end else if (clr_i || snp_kill_o) begin
      valid_q <= 1'b0;
    end
  end

  assert_snoop_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill_o && !set_i |=> !probe_hit_o);
  assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !snp_on_set |=> valid_q && blk_q == $past(set_blk_i));
  assert_load_snoop_same_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && snp_on_set |=> !valid_q);
  assert_clear_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !valid_q);
  assert_other_snoop_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !set_i && !clr_i && !snp_kill_o |=> valid_q && $stable(blk_q));
endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              probe_hit,
  input  logic              snp_kill,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              req_ready,
  output logic              ll_set,
  output logic              resv_clr,
  output logic              bus_req,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rsp_done,
  output logic              rsp_ok,
  output logic [DATA_W-1:0] rsp_rdata
);
  llsc_state_e       state_q, state_d;
  llsc_op_e          op;
  logic [ADDR_W-1:0] sc_addr_q;
  logic [DATA_W-1:0] sc_data_q;
  logic              done_q, ok_q;
  logic [DATA_W-1:0] rdata_q;

  // named internal events
  logic accept, ll_acc, st_acc, sc_acc;
  logic in_arb, in_load;
  logic sc_issue, sc_rej_issue, sc_commit, sc_kill_arb, sc_reject;

  assign op        = llsc_op_e'(req_op);
  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign ll_acc    = accept && (op == OP_LL);
  assign st_acc    = accept && (op == OP_ST);
  assign sc_acc    = accept && (op == OP_SC);
  assign in_arb    = (state_q == S_ARB);
  assign in_load   = (state_q == S_LOAD);

  assign sc_issue     = sc_acc && probe_hit && !snp_kill;
  assign sc_rej_issue = sc_acc && !sc_issue;
  assign sc_commit    = in_arb && bus_gnt && !snp_kill;
  assign sc_kill_arb  = in_arb && snp_kill;
  assign sc_reject    = sc_rej_issue || sc_kill_arb;

  assign ll_set    = ll_acc;
  assign resv_clr  = sc_reject || sc_commit || (st_acc && probe_hit);
  assign bus_req   = in_arb;
  assign mem_re    = ll_acc;
  assign mem_we    = st_acc || sc_commit;
  assign mem_addr  = in_arb ? sc_addr_q : req_addr;
  assign mem_wdata = in_arb ? sc_data_q : req_wdata;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (ll_acc)        state_d = S_LOAD;
        else if (sc_issue) state_d = S_ARB;
      end
      S_LOAD: state_d = S_IDLE;
      S_ARB:  if (sc_commit || sc_kill_arb) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      sc_addr_q <= '0;
      sc_data_q <= '0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (sc_acc) begin
        sc_addr_q <= req_addr;
        sc_data_q <= req_wdata;
      end
      done_q <= st_acc || sc_reject || sc_commit || in_load;
      ok_q   <= st_acc || sc_commit || in_load;
      if (in_load) rdata_q <= mem_rdata;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_ok    = ok_q;
  assign rsp_rdata = rdata_q;

  assert_load_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ll_acc |=> ##1 (rsp_done && rsp_ok));
  assert_commit_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sc_commit |=> rsp_done && rsp_ok);
  assert_reject_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sc_reject |=> rsp_done && !rsp_ok);
  assert_fast_reject_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rej_issue |=> !bus_req);
  assert_kill_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_kill_arb |-> !mem_we);
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !snp_kill |=> bus_req && $stable(mem_addr));
  assert_store_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_acc |-> mem_we ##1 (rsp_done && rsp_ok));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 4,
  localparam int BLK_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_ok,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              snp_valid,
  input  logic [BLK_W-1:0]  snp_blk,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic [BLK_W-1:0] req_blk;
  logic             ll_set, resv_clr, probe_hit, snp_kill;

  assign req_blk = blk_of(req_addr);

  llsc_resv #(.BLK_W(BLK_W)) u_resv (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (ll_set),
    .set_blk_i   (req_blk),
    .clr_i       (resv_clr),
    .snp_valid_i (snp_valid),
    .snp_blk_i   (snp_blk),
    .probe_blk_i (req_blk),
    .probe_hit_o (probe_hit),
    .snp_kill_o  (snp_kill)
  );

  llsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .probe_hit (probe_hit),
    .snp_kill  (snp_kill),
    .bus_gnt   (bus_gnt),
    .mem_rdata (mem_rdata),
    .req_ready (req_ready),
    .ll_set    (ll_set),
    .resv_clr  (resv_clr),
    .bus_req   (bus_req),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rsp_done  (rsp_done),
    .rsp_ok    (rsp_ok),
    .rsp_rdata (rsp_rdata)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> !rsp_done && !bus_req && req_ready);
  assert_write_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && bus_req |-> bus_gnt);
endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_done, rsp_ok;
  logic [31:0] rsp_rdata;
  logic        snp_valid = 1'b0;
  logic [11:0] snp_blk = '0;
  logic        bus_req, bus_gnt, mem_re, mem_we;
  logic        gnt_en = 1'b1;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [256];

  int n_chk = 0, n_bad = 0, we_cnt = 0, breq_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign bus_gnt = bus_req & gnt_en;

  llsc_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
    .snp_valid(snp_valid), .snp_blk(snp_blk), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
    end else begin
      if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && mem_we) we_cnt++;
    if (rst_n && bus_req) breq_cnt++;
  end

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // snp_mode: 0 none, 1 snoop one cycle before, 2 snoop in the accept cycle
  task automatic do_op(input logic [1:0] op, input logic [15:0] addr, input logic [31:0] data,
                       input int snp_mode, input logic [11:0] sblk,
                       output logic ok, output logic [31:0] rd, output int lat,
                       output int wes, output int breqs);
    int we0, br0;
    if (snp_mode == 1) begin
      snp_valid = 1'b1; snp_blk = sblk;
      @(negedge clk);
      snp_valid = 1'b0;
    end
    we0 = we_cnt; br0 = breq_cnt;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = data;
    if (snp_mode == 2) begin snp_valid = 1'b1; snp_blk = sblk; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    #1;
    ok = rsp_ok; rd = rsp_rdata;
    wes = we_cnt - we0; breqs = breq_cnt - br0;
    @(negedge clk);
  endtask

  // conditional store with grant withheld for wait_cyc cycles; kill snoops with the grant
  task automatic sc_held(input logic [15:0] addr, input logic [31:0] data, input int wait_cyc,
                         input bit kill, input logic [11:0] sblk, input string req,
                         input logic exp_ok);
    int we0;
    gnt_en = 1'b0;
    we0 = we_cnt;
    req_valid = 1'b1; req_op = 2'd2; req_addr = addr; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < wait_cyc; i++) begin
      chk(bus_req === 1'b1 && rsp_done === 1'b0, req, {31'd0, bus_req}, 32'd1);
      if (i < wait_cyc - 1) @(negedge clk);
    end
    gnt_en = 1'b1;
    if (kill) begin snp_valid = 1'b1; snp_blk = sblk; end
    @(negedge clk);
    snp_valid = 1'b0;
    chk(rsp_done === 1'b1 && rsp_ok === exp_ok, req, {30'd0, rsp_done, rsp_ok}, {30'd0, 1'b1, exp_ok});
    chk(bus_req === 1'b0, req, {31'd0, bus_req}, 32'd0);
    #1;
    chk(we_cnt - we0 == (exp_ok ? 1 : 0), req, we_cnt - we0, exp_ok ? 1 : 0);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [31:0] data;
    logic        pre;
    logic [11:0] snp;
    logic        ok;
    logic [31:0] rd;
    logic [1:0]  lat;
    logic [1:0]  we;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h0040, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0010, 2'd2, 2'd0, 4'd1},  // R1
    '{2'd2, 16'h0044, 32'h1111_1111, 1'b0, 12'h0, 1'b1, 32'h0, 2'd2, 2'd1, 4'd2},  // R2 other offset
    '{2'd2, 16'h0040, 32'h22, 1'b0, 12'h0, 1'b0, 32'h0, 2'd1, 2'd0, 4'd7},         // R7
    '{2'd1, 16'h0080, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0020, 2'd2, 2'd0, 4'd1},
    '{2'd2, 16'h0080, 32'h33, 1'b1, 12'h008, 1'b0, 32'h0, 2'd1, 2'd0, 4'd3},       // R3
    '{2'd1, 16'h00C0, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0030, 2'd2, 2'd0, 4'd1},
    '{2'd2, 16'h00C4, 32'h44, 1'b1, 12'h00D, 1'b1, 32'h0, 2'd2, 2'd1, 4'd4},       // R4
    '{2'd1, 16'h0100, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0040, 2'd2, 2'd0, 4'd1},
    '{2'd1, 16'h0140, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0050, 2'd2, 2'd0, 4'd8},
    '{2'd2, 16'h0100, 32'h55, 1'b0, 12'h0, 1'b0, 32'h0, 2'd1, 2'd0, 4'd8},         // R8
    '{2'd2, 16'h0140, 32'h66, 1'b0, 12'h0, 1'b0, 32'h0, 2'd1, 2'd0, 4'd6},         // R6
    '{2'd1, 16'h0180, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0060, 2'd2, 2'd0, 4'd1},
    '{2'd3, 16'h0190, 32'h77, 1'b0, 12'h0, 1'b1, 32'h0, 2'd1, 2'd1, 4'd9},         // R9 other block
    '{2'd2, 16'h0188, 32'h88, 1'b0, 12'h0, 1'b1, 32'h0, 2'd2, 2'd1, 4'd9},
    '{2'd1, 16'h01C0, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0070, 2'd2, 2'd0, 4'd1},
    '{2'd3, 16'h01CC, 32'h99, 1'b0, 12'h0, 1'b1, 32'h0, 2'd1, 2'd1, 4'd9},         // R9 same block
    '{2'd2, 16'h01C0, 32'hAA, 1'b0, 12'h0, 1'b0, 32'h0, 2'd1, 2'd0, 4'd9},
    '{2'd1, 16'h0044, 32'h0, 1'b0, 12'h0, 1'b1, 32'h1111_1111, 2'd2, 2'd0, 4'd2},  // R2 write landed
    '{2'd1, 16'h00C4, 32'h0, 1'b0, 12'h0, 1'b1, 32'h44, 2'd2, 2'd0, 4'd4},
    '{2'd1, 16'h0080, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0020, 2'd2, 2'd0, 4'd3},
    '{2'd1, 16'h0100, 32'h0, 1'b0, 12'h0, 1'b1, 32'hA000_0040, 2'd2, 2'd0, 4'd8},
    '{2'd1, 16'h0190, 32'h0, 1'b0, 12'h0, 1'b1, 32'h77, 2'd2, 2'd0, 4'd9}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic ok; logic [31:0] rd; int lat, wes, brs;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rsp_done === 1'b0 && bus_req === 1'b0 && mem_we === 1'b0 && req_ready === 1'b1,
        "R11", {28'd0, rsp_done, bus_req, mem_we, req_ready}, 32'd1);
    do_op(2'd2, 16'h0040, 32'hDEAD, 0, 12'h0, ok, rd, lat, wes, brs);
    chk(ok === 1'b0 && wes == 0 && brs == 0, "R11", {31'd0, ok}, 32'd0);   // also R6: no reservation

    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
      do_op(VEC[v].op, VEC[v].addr, VEC[v].data, VEC[v].pre ? 1 : 0, VEC[v].snp, ok, rd, lat, wes, brs);
      chk(ok === VEC[v].ok, tag, {31'd0, ok}, {31'd0, VEC[v].ok});
      chk(lat == VEC[v].lat, {tag, " latency R10"}, lat, VEC[v].lat);
      chk(wes == VEC[v].we, {tag, " writes"}, wes, VEC[v].we);
      if (VEC[v].op == 2'd1) chk(rd === VEC[v].rd, {tag, " data"}, rd, VEC[v].rd);
      if (VEC[v].op == 2'd2 && !VEC[v].ok) chk(brs == 0, {tag, " no bus R3"}, brs, 0);
    end

    // R5: snoop arrives together with the grant while waiting
    do_op(2'd1, 16'h0200, 32'h0, 0, 12'h0, ok, rd, lat, wes, brs);
    chk(rd === 32'hA000_0080, "R5 setup", rd, 32'hA000_0080);
    sc_held(16'h0200, 32'hBAD0, 3, 1'b1, 12'h020, "R5 kill", 1'b0);
    do_op(2'd1, 16'h0200, 32'h0, 0, 12'h0, ok, rd, lat, wes, brs);
    chk(rd === 32'hA000_0080, "R5 no write", rd, 32'hA000_0080);

    // R5: delayed grant without snoop commits
    do_op(2'd1, 16'h0210, 32'h0, 0, 12'h0, ok, rd, lat, wes, brs);
    sc_held(16'h0210, 32'hBEEF, 3, 1'b0, 12'h0, "R5 late grant", 1'b1);
    do_op(2'd1, 16'h0210, 32'h0, 0, 12'h0, ok, rd, lat, wes, brs);
    chk(rd === 32'hBEEF, "R5 late grant data", rd, 32'hBEEF);

    // R5: unrelated snoop with the grant does not kill
    do_op(2'd1, 16'h0220, 32'h0, 0, 12'h0, ok, rd, lat, wes, brs);
    sc_held(16'h0220, 32'hCAFE, 2, 1'b1, 12'h023, "R5 other snoop", 1'b1);

    // R12: snoop to the same block in the linked-load cycle
    do_op(2'd1, 16'h0240, 32'h0, 2, 12'h024, ok, rd, lat, wes, brs);
    chk(ok === 1'b1 && rd === 32'hA000_0090, "R12 load", rd, 32'hA000_0090);
    do_op(2'd2, 16'h0240, 32'h5A5A, 0, 12'h0, ok, rd, lat, wes, brs);
    chk(ok === 1'b0 && wes == 0 && brs == 0, "R12", {31'd0, ok}, 32'd0);

    finish_run();
  end
endmodule